// File: doc/BRIEF.md
# Serial Configuration Frame Receiver

This block takes configuration words from a host over one serial data line. The host sends a separate word strobe, and the block takes one bit on each falling edge of that strobe. Each frame holds a low start bit, a 3-bit register select and a 12-bit payload, and every field is sent most significant bit first. The frame takes effect only after the line has stayed high for a set number of strobe periods. That guard rejects noise and frames that end early.

Six 12-bit configuration words live inside the block. Their fields go straight out on dedicated pins: receive gain code, the two external gain pins, a filter-rate select, transmit attenuation, three general-purpose outputs, the sample sign format, three loopback controls, a receive enable, a word-clock divider code together with its one-hot ratio, an oscillator tuning DAC word, and the edge selects for transmit and receive latching. The block also keeps a clip flag. A clip event sets it, and a committed mode frame whose clip bit is 0 clears it.

Top module: `cfg_serial_ctrl`

## Requirements
- R1: After a synchronous high `rst`, all six configuration words are zero, so every field output is 0, except `wclk_ratio`, which reads 4'b0001. `clip_flag` is 0.
- R2: `sdin` is sampled only in the clock cycle after `wstrb` goes from 1 to 0. Changes on `sdin` while `wstrb` stays level, or at a rising edge of `wstrb`, are never sampled. A frame is 16 samples: a 0 start bit, then register select bits 2..0, then payload bits 11..0, each field MSB first.
- R3: A frame is written only on its 16th consecutive high sample after the payload. With 15 high samples, every output keeps its old value.
- R4: A low sample that arrives before the 16th high sample drops the pending frame and counts as the start bit of a new frame.
- R5: Frames with select 6 or 7 are received and completed but change no output.
- R6: Select 0: `rx_gain` = payload[5:0], `gain_pins` = payload[7:6], `rx_filt_sel` = payload[8].
- R7: Select 1: `tx_atten` = payload[4:0], `gpo` = payload[7:5], `one_sign` = payload[9] (1 = one sign bit, 0 = two sign bits).
- R8: Select 2: `wclk_div` = payload[5:4], `rx_en` = payload[6], `ana_loop` = payload[7], `dig_loop` = payload[8]. `wclk_ratio` is 1 shifted left by `wclk_div`, which gives ratios 1, 2, 4 and 8.
- R9: A high `clip_evt` sets `clip_flag` on the next clock. A committed select-2 frame with payload[3] = 0 clears it. A select-2 frame with payload[3] = 1 leaves it set.
- R10: Select 3: `osc_dac` = payload[9:0]. Select 4: `tx_edge` = payload[0], `rx_edge` = payload[1], `rx2tx_loop` = payload[2]. Select 5: `aux_word` = payload[11:0].
- R11: A committed frame changes only the word it selects. The other words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wstrb | input | 1 | Word strobe; its falling edge takes one bit |
| sdin | input | 1 | Serial configuration data, idle high |
| clip_evt | input | 1 | Pulse marking a receive clip event |
| rx_gain | output | 6 | Receive gain code |
| gain_pins | output | 2 | External gain-control pins |
| rx_filt_sel | output | 1 | Receive filter rate select |
| tx_atten | output | 5 | Transmit attenuation code, dB |
| gpo | output | 3 | General-purpose outputs |
| one_sign | output | 1 | 1 = one sign bit, 0 = two sign bits |
| dig_loop | output | 1 | Digital loopback, transmit to receive |
| ana_loop | output | 1 | Analog loopback, transmit to receive |
| rx_en | output | 1 | Receive enable |
| wclk_div | output | 2 | Word-clock divider code |
| wclk_ratio | output | 4 | One-hot divide ratio 1/2/4/8 |
| clip_flag | output | 1 | Sticky clip indication |
| osc_dac | output | 10 | Oscillator tuning DAC word |
| tx_edge | output | 1 | Transmit nibble latch-edge select |
| rx_edge | output | 1 | Receive nibble latch-edge select |
| rx2tx_loop | output | 1 | Loopback from receive into transmit |
| aux_word | output | 12 | Word held at select 5 |

## Verification
The bench sends a frame that is one stop bit short. A receiver that commits too early would already show the new oscillator word; the bench then confirms that one more high bit does the write. It breaks off a frame by starting a new one during the stop run. A design that ignores the restart would lose the second frame or write the first one. It also puts glitches on the data line while the strobe is level and changes data at each rising edge, which exposes sampling on the wrong edge. Frames to the reserved selects, and the clip flag surviving a mode write with the clip bit at 1, catch decoders that write past the six words or clear the flag unconditionally.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_STOP  = 2'd2
  } rx_state_e;

  // register selects
  localparam int SEL_RX   = 0;
  localparam int SEL_TX   = 1;
  localparam int SEL_MODE = 2;
  localparam int SEL_OSC  = 3;
  localparam int SEL_IFC  = 4;
  localparam int SEL_AUX  = 5;

  // field positions inside a 12-bit payload
  localparam int RXG_LSB  = 0;
  localparam int RXG_W    = 6;
  localparam int RXP_LSB  = 6;
  localparam int RXF_BIT  = 8;
  localparam int TXA_LSB  = 0;
  localparam int TXA_W    = 5;
  localparam int GPO_LSB  = 5;
  localparam int GPO_W    = 3;
  localparam int SGN_BIT  = 9;
  localparam int CLR_BIT  = 3;
  localparam int DIV_LSB  = 4;
  localparam int DIV_W    = 2;
  localparam int RXEN_BIT = 6;
  localparam int ALB_BIT  = 7;
  localparam int DLB_BIT  = 8;
  localparam int OSC_W    = 10;
  localparam int TXE_BIT  = 0;
  localparam int RXE_BIT  = 1;
  localparam int RTL_BIT  = 2;
endpackage

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int ID_W     = 3,
  parameter int STOP_MIN = 16,
  localparam int PAY_W   = FRAME_W - 1,
  localparam int DATA_W  = PAY_W - ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wstrb,
  input  logic              sdin,
  output logic              wr_en,
  output logic [ID_W-1:0]   wr_id,
  output logic [DATA_W-1:0] wr_data
);
  localparam int BCNT_W = $clog2(FRAME_W);
  localparam int SCNT_W = $clog2(STOP_MIN + 1);

  logic              strb_q;
  logic              tick;
  rx_state_e         state;
  logic [PAY_W-1:0]  shreg;
  logic [BCNT_W-1:0] bcnt;
  logic [SCNT_W-1:0] scnt;

  assign tick = strb_q & ~wstrb;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q  <= 1'b0;
      state   <= RX_IDLE;
      shreg   <= '0;
      bcnt    <= '0;
      scnt    <= '0;
      wr_en   <= 1'b0;
      wr_id   <= '0;
      wr_data <= '0;
    end else begin
      strb_q <= wstrb;
      wr_en  <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!sdin) begin
              state <= RX_SHIFT;
              bcnt  <= BCNT_W'(1);
            end
          end
          RX_SHIFT: begin
            shreg <= {shreg[PAY_W-2:0], sdin};
            if (bcnt == BCNT_W'(FRAME_W - 1)) begin
              state <= RX_STOP;
              scnt  <= '0;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (!sdin) begin
              state <= RX_SHIFT;
              bcnt  <= BCNT_W'(1);
            end else if (scnt == SCNT_W'(STOP_MIN - 1)) begin
              state   <= RX_IDLE;
              wr_en   <= 1'b1;
              wr_id   <= shreg[PAY_W-1 -: ID_W];
              wr_data <= shreg[DATA_W-1:0];
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R3
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(state == RX_STOP && tick && sdin));

  // R4
  restart_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_STOP && tick && !sdin) |=> (state == RX_SHIFT && !wr_en));

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(state) && $stable(shreg)));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NUM_REGS = 6,
  parameter int ID_W     = 3,
  parameter int DATA_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ID_W-1:0]            wr_id,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              id_ok;

  assign id_ok = int'(wr_id) < NUM_REGS;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en && id_ok) begin
      mem[wr_id] <= wr_data;
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    assign regs_flat[k*DATA_W +: DATA_W] = mem[k];

    // R11
    other_word_kept_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && int'(wr_id) == k) |=> $stable(mem[k]));
  end

  // R5
  reserved_sel_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !id_ok) |=> $stable(regs_flat));
endmodule

// File: rtl/cfg_field_map.sv
module cfg_field_map
  import cfg_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int ID_W     = 3,
  parameter int DATA_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  input  logic                       wr_en,
  input  logic [ID_W-1:0]            wr_id,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       clip_evt,
  output logic [RXG_W-1:0]           rx_gain,
  output logic [1:0]                 gain_pins,
  output logic                       rx_filt_sel,
  output logic [TXA_W-1:0]           tx_atten,
  output logic [GPO_W-1:0]           gpo,
  output logic                       one_sign,
  output logic                       dig_loop,
  output logic                       ana_loop,
  output logic                       rx_en,
  output logic [DIV_W-1:0]           wclk_div,
  output logic [(1<<DIV_W)-1:0]      wclk_ratio,
  output logic                       clip_flag,
  output logic [OSC_W-1:0]           osc_dac,
  output logic                       tx_edge,
  output logic                       rx_edge,
  output logic                       rx2tx_loop,
  output logic [DATA_W-1:0]          aux_word
);
  logic [DATA_W-1:0] w_rx, w_tx, w_md, w_osc, w_ifc;
  logic              mode_wr;

  assign w_rx  = regs_flat[SEL_RX*DATA_W   +: DATA_W];
  assign w_tx  = regs_flat[SEL_TX*DATA_W   +: DATA_W];
  assign w_md  = regs_flat[SEL_MODE*DATA_W +: DATA_W];
  assign w_osc = regs_flat[SEL_OSC*DATA_W  +: DATA_W];
  assign w_ifc = regs_flat[SEL_IFC*DATA_W  +: DATA_W];
  assign aux_word = regs_flat[SEL_AUX*DATA_W +: DATA_W];

  assign rx_gain     = w_rx[RXG_LSB +: RXG_W];
  assign gain_pins   = w_rx[RXP_LSB +: 2];
  assign rx_filt_sel = w_rx[RXF_BIT];
  assign tx_atten    = w_tx[TXA_LSB +: TXA_W];
  assign gpo         = w_tx[GPO_LSB +: GPO_W];
  assign one_sign    = w_tx[SGN_BIT];
  assign wclk_div    = w_md[DIV_LSB +: DIV_W];
  assign rx_en       = w_md[RXEN_BIT];
  assign ana_loop    = w_md[ALB_BIT];
  assign dig_loop    = w_md[DLB_BIT];
  assign osc_dac     = w_osc[OSC_W-1:0];
  assign tx_edge     = w_ifc[TXE_BIT];
  assign rx_edge     = w_ifc[RXE_BIT];
  assign rx2tx_loop  = w_ifc[RTL_BIT];

  for (genvar r = 0; r < (1 << DIV_W); r++) begin : g_ratio
    assign wclk_ratio[r] = (int'(wclk_div) == r);
  end

  assign mode_wr = wr_en && (wr_id == ID_W'(SEL_MODE));

  // a fresh clip event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)                                  clip_flag <= 1'b0;
    else if (clip_evt)                        clip_flag <= 1'b1;
    else if (mode_wr && !wr_data[CLR_BIT])    clip_flag <= 1'b0;
  end

  // R9
  clip_set_chk: assert property (@(posedge clk) disable iff (rst)
    clip_evt |=> clip_flag);

  // R9
  clip_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !wr_data[CLR_BIT] && !clip_evt) |=> !clip_flag);

  // R9
  clip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clip_flag && !(mode_wr && !wr_data[CLR_BIT])) |=> clip_flag);
endmodule

// File: rtl/cfg_serial_ctrl.sv
module cfg_serial_ctrl
  import cfg_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int ID_W     = 3,
  parameter int STOP_MIN = 16,
  parameter int NUM_REGS = 6,
  localparam int DATA_W  = FRAME_W - 1 - ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wstrb,
  input  logic              sdin,
  input  logic              clip_evt,
  output logic [5:0]        rx_gain,
  output logic [1:0]        gain_pins,
  output logic              rx_filt_sel,
  output logic [4:0]        tx_atten,
  output logic [2:0]        gpo,
  output logic              one_sign,
  output logic              dig_loop,
  output logic              ana_loop,
  output logic              rx_en,
  output logic [1:0]        wclk_div,
  output logic [3:0]        wclk_ratio,
  output logic              clip_flag,
  output logic [9:0]        osc_dac,
  output logic              tx_edge,
  output logic              rx_edge,
  output logic              rx2tx_loop,
  output logic [DATA_W-1:0] aux_word
);
  logic                       wr_en;
  logic [ID_W-1:0]            wr_id;
  logic [DATA_W-1:0]          wr_data;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  cfg_frame_rx #(
    .FRAME_W (FRAME_W),
    .ID_W    (ID_W),
    .STOP_MIN(STOP_MIN)
  ) u_rx (
    .clk    (clk),
    .rst    (rst),
    .wstrb  (wstrb),
    .sdin   (sdin),
    .wr_en  (wr_en),
    .wr_id  (wr_id),
    .wr_data(wr_data)
  );

  cfg_regfile #(
    .NUM_REGS(NUM_REGS),
    .ID_W    (ID_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_id    (wr_id),
    .wr_data  (wr_data),
    .regs_flat(regs_flat)
  );

  cfg_field_map #(
    .NUM_REGS(NUM_REGS),
    .ID_W    (ID_W),
    .DATA_W  (DATA_W)
  ) u_map (
    .clk        (clk),
    .rst        (rst),
    .regs_flat  (regs_flat),
    .wr_en      (wr_en),
    .wr_id      (wr_id),
    .wr_data    (wr_data),
    .clip_evt   (clip_evt),
    .rx_gain    (rx_gain),
    .gain_pins  (gain_pins),
    .rx_filt_sel(rx_filt_sel),
    .tx_atten   (tx_atten),
    .gpo        (gpo),
    .one_sign   (one_sign),
    .dig_loop   (dig_loop),
    .ana_loop   (ana_loop),
    .rx_en      (rx_en),
    .wclk_div   (wclk_div),
    .wclk_ratio (wclk_ratio),
    .clip_flag  (clip_flag),
    .osc_dac    (osc_dac),
    .tx_edge    (tx_edge),
    .rx_edge    (rx_edge),
    .rx2tx_loop (rx2tx_loop),
    .aux_word   (aux_word)
  );
endmodule

// File: tb/cfg_serial_ctrl_test.sv
module cfg_serial_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wstrb = 1'b0;
  logic sdin = 1'b1;
  logic clip_evt = 1'b0;
  logic [5:0] rx_gain;
  logic [1:0] gain_pins;
  logic rx_filt_sel;
  logic [4:0] tx_atten;
  logic [2:0] gpo;
  logic one_sign, dig_loop, ana_loop, rx_en;
  logic [1:0] wclk_div;
  logic [3:0] wclk_ratio;
  logic clip_flag;
  logic [9:0] osc_dac;
  logic tx_edge, rx_edge, rx2tx_loop;
  logic [11:0] aux_word;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [11:0] model [8];

  always #5 clk = ~clk;

  cfg_serial_ctrl uut (
    .clk(clk), .rst(rst), .wstrb(wstrb), .sdin(sdin), .clip_evt(clip_evt),
    .rx_gain(rx_gain), .gain_pins(gain_pins), .rx_filt_sel(rx_filt_sel),
    .tx_atten(tx_atten), .gpo(gpo), .one_sign(one_sign), .dig_loop(dig_loop),
    .ana_loop(ana_loop), .rx_en(rx_en), .wclk_div(wclk_div),
    .wclk_ratio(wclk_ratio), .clip_flag(clip_flag), .osc_dac(osc_dac),
    .tx_edge(tx_edge), .rx_edge(rx_edge), .rx2tx_loop(rx2tx_loop),
    .aux_word(aux_word)
  );

  // {select[2:0], payload[11:0]}
  localparam logic [14:0] VEC [10] = '{
    {3'd0, 12'h1A5}, {3'd1, 12'h2B7}, {3'd2, 12'h1F8}, {3'd3, 12'h3FF},
    {3'd4, 12'h005}, {3'd5, 12'hABC}, {3'd6, 12'hFFF}, {3'd7, 12'h123},
    {3'd1, 12'h000}, {3'd2, 12'h030}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R6 rx_gain",     64'(rx_gain),     64'(model[0][5:0]));
    chk("R6 gain_pins",   64'(gain_pins),   64'(model[0][7:6]));
    chk("R6 rx_filt_sel", 64'(rx_filt_sel), 64'(model[0][8]));
    chk("R7 tx_atten",    64'(tx_atten),    64'(model[1][4:0]));
    chk("R7 gpo",         64'(gpo),         64'(model[1][7:5]));
    chk("R7 one_sign",    64'(one_sign),    64'(model[1][9]));
    chk("R8 mode fields", 64'({dig_loop, ana_loop, rx_en, wclk_div}),
        64'({model[2][8], model[2][7], model[2][6], model[2][5:4]}));
    chk("R8 wclk_ratio",  64'(wclk_ratio),  64'(4'b0001 << model[2][5:4]));
    chk("R10 osc_dac",    64'(osc_dac),     64'(model[3][9:0]));
    chk("R10 ifc fields", 64'({rx2tx_loop, rx_edge, tx_edge}), 64'(model[4][2:0]));
    chk("R10 aux_word",   64'(aux_word),    64'(model[5]));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdin = ~b; wstrb = 1'b1;   // rising edge carries wrong value
    @(negedge clk); sdin = b;
    @(negedge clk); wstrb = 1'b0;
  endtask

  task automatic noise();
    for (int i = 0; i < 4; i++) begin @(negedge clk); sdin = ~sdin; end
    @(negedge clk); wstrb = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); sdin = ~sdin; end
  endtask

  task automatic send_frame(input logic [2:0] id, input logic [11:0] d,
                            input int nstop, input bit glitch);
    send_bit(1'b0);
    for (int i = 2; i >= 0; i--) send_bit(id[i]);
    if (glitch) noise();
    for (int i = 11; i >= 0; i--) send_bit(d[i]);
    for (int i = 0; i < nstop; i++) send_bit(1'b1);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 fields zero", {rx_gain, gain_pins, rx_filt_sel, tx_atten, gpo, one_sign,
        dig_loop, ana_loop, rx_en, wclk_div, clip_flag, osc_dac, tx_edge, rx_edge,
        rx2tx_loop, aux_word}, 64'd0);
    chk("R1 wclk_ratio", 64'(wclk_ratio), 64'd1);

    // table walk: R2 R5 R6 R7 R8 R10 R11
    for (int v = 0; v < 10; v++) begin
      send_frame(VEC[v][14:12], VEC[v][11:0], 16, v == 2);
      settle();
      if (VEC[v][14:12] < 3'd6) model[VEC[v][14:12]] = VEC[v][11:0];
      check_all();
    end

    // R3: one stop bit short, then complete it
    send_frame(3'd3, 12'h155, 15, 1'b0);
    settle();
    chk("R3 no write at 15 stops", 64'(osc_dac), 64'(model[3][9:0]));
    send_bit(1'b1);
    settle();
    model[3] = 12'h155;
    chk("R3 write at 16th stop", 64'(osc_dac), 64'h155);

    // R4: interrupted frame dropped, low bit starts next frame
    send_frame(3'd4, 12'h007, 5, 1'b0);
    send_frame(3'd3, 12'h0AA, 16, 1'b0);
    settle();
    model[3] = 12'h0AA;
    chk("R4 dropped frame", 64'({rx2tx_loop, rx_edge, tx_edge}), 64'(model[4][2:0]));
    chk("R4 restarted frame", 64'(osc_dac), 64'h0AA);
    check_all();

    // R9 clip flag
    @(negedge clk); clip_evt = 1'b1;
    @(negedge clk); clip_evt = 1'b0;
    chk("R9 clip set", 64'(clip_flag), 64'd1);
    send_frame(3'd2, 12'h0C8, 16, 1'b0);
    settle();
    model[2] = 12'h0C8;
    chk("R9 clip kept on bit3=1", 64'(clip_flag), 64'd1);
    check_all();
    send_frame(3'd2, 12'h020, 16, 1'b0);
    settle();
    model[2] = 12'h020;
    chk("R9 clip cleared on bit3=0", 64'(clip_flag), 64'd0);
    chk("R8 ratio 4", 64'(wclk_ratio), 64'd4);

    // R1 again after a mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 reset clears words", 64'({osc_dac, aux_word, clip_flag}), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule